// File: doc/BRIEF.md
# Address-Keyed Pad Cipher for a Memory Bus

This block sits between a 16-bit processor and an ordinary binary memory, so that the words held in the memory and carried on its data bus are not plaintext. It derives a 16-bit pad from the access address and a 64-bit key, and XORs the pad with the data word. On a store, the XOR encrypts the word before the memory sees it. On a load, the same XOR turns the returned word back into plaintext. The top two address bits select one of several protection regions, and each region has its own key register.

The pad is a keyed hash with four rounds. Every round mixes one 16-bit slice of the key into the state, passes each nibble through a 4-bit substitution box, and then transposes the state as a 4x4 bit matrix. A final key XOR follows the last round. For a load, the pad is computed in the same cycle that the memory read is issued, so the pad is ready when the data returns. A store passes through a small state machine with three states. WS_IDLE waits and takes a new store into WS_HASH. WS_HASH computes the ciphertext and the write-once check and goes to WS_STORE when the check passes, or back to WS_IDLE when it reports a violation. WS_STORE drives the memory write and goes to WS_HASH if it takes another store, otherwise to WS_IDLE.

A region can be put in write-once mode. In that mode a second store to a location that has already been written is refused and flagged. A region's key can also be wiped after use, and the wiped key then reads as zero.

Top module: `bus_pad_cipher`

## Requirements
- R1: After reset all keys are zero, no region is write-once, no location is marked written, `cpu_wready` is 1, and `mem_we`, `cpu_rvalid` and `viol` are 0.
- R2: The pad for address A and key K is computed as follows. The state starts at A. For each round r = 0..3, the state is XORed with K[16r+15:16r]. Each nibble n (bits 4n+3:4n) is then replaced through the table 0..15 -> 3,8,15,1,10,6,5,11,14,13,4,7,9,0,12,2. The state is then transposed so that input bit 4i+j moves to output bit 4j+i. After the last round the state is XORed with K[15:0]. With A=0 and K=0 the pad is 0xA244.
- R3: A load issued with `cpu_req`=1 and `cpu_we`=0 drives `mem_re`=1 and `mem_raddr`=`cpu_addr` in the same cycle. In the next cycle `cpu_rvalid`=1 and `cpu_rdata` = `mem_rdata` XOR pad(address, key of region `cpu_addr[15:14]` at issue time).
- R4: A store is accepted when `cpu_req`, `cpu_we` and `cpu_wready` are all 1. If the store is not refused, `mem_we`=1 for exactly one cycle, two cycles after acceptance, with `mem_waddr` = the address and `mem_wdata` = data XOR pad(address, region key as held in the cycle after acceptance).
- R5: `cpu_wready` is 0 in the cycle after a store is accepted and 1 otherwise, so stores held back to back are taken every second cycle.
- R6: `cfg_we` loads `cfg_key` and `cfg_wonce` into region `cfg_sel`. Accesses use the new key from the next cycle on.
- R7: `cfg_clr` (which has priority over `cfg_we`) sets the key of region `cfg_sel` to zero and leaves its write-once mode unchanged.
- R8: The location of an address is {addr[15:14], addr[5:0]}. Every store that is carried out marks its location. A store to a marked location in a write-once region gives no `mem_we` and a one-cycle `viol` pulse, two cycles after acceptance. In other regions, repeated stores are carried out.
- R9: A load of a word stored under an unchanged key returns the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load key and mode into a region |
| cfg_clr | input | 1 | Wipe the key of a region |
| cfg_sel | input | 2 | Region addressed by cfg_we / cfg_clr |
| cfg_key | input | 64 | Key value to load |
| cfg_wonce | input | 1 | Write-once mode to load |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 16 | Store data (plaintext) |
| cpu_wready | output | 1 | A store can be accepted this cycle |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 16 | Decrypted load data |
| mem_re | output | 1 | Memory read strobe |
| mem_raddr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_re |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Encrypted store data |
| viol | output | 1 | Refused write-once store |

## Verification
The first corner case is the hash itself. A fixed vector (address 0, key 0) catches a wrong table entry, a transpose in the wrong direction, or a key slice taken from the wrong round, because any of these changes the read pad. Stores held back to back test the WS_STORE-to-WS_HASH path. A design that took a store in WS_HASH, or dropped the one taken in WS_STORE, would write the wrong address or lose a word.

Repeated stores into a write-once region against repeated stores into a normal region check the write-once logic. A design that marked the location late, or checked the mode of the wrong region, would either write twice or refuse a legal store. Wiping a key and changing a key between the store and the load show whether the pad uses the key from the correct cycle.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int unsigned DW  = 16;
    localparam int unsigned NIB = 4;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_HASH  = 2'd1,
        WS_STORE = 2'd2
    } wstate_t;

    function automatic logic [3:0] sub_nibble(input logic [3:0] x);
        logic [3:0] y;
        unique case (x)
            4'h0: y = 4'h3;
            4'h1: y = 4'h8;
            4'h2: y = 4'hF;
            4'h3: y = 4'h1;
            4'h4: y = 4'hA;
            4'h5: y = 4'h6;
            4'h6: y = 4'h5;
            4'h7: y = 4'hB;
            4'h8: y = 4'hE;
            4'h9: y = 4'hD;
            4'hA: y = 4'h4;
            4'hB: y = 4'h7;
            4'hC: y = 4'h9;
            4'hD: y = 4'h0;
            4'hE: y = 4'hC;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/pad_round.sv
module pad_round
    import bpc_pkg::*;
(
    input  word_t st_in,
    input  word_t rkey,
    output word_t st_out
);
    word_t mixed;
    word_t subbed;

    assign mixed = st_in ^ rkey;

    for (genvar n = 0; n < NIB; n++) begin : g_sub
        assign subbed[NIB*n +: NIB] = sub_nibble(mixed[NIB*n +: NIB]);
    end

    for (genvar i = 0; i < NIB; i++) begin : g_row
        for (genvar j = 0; j < NIB; j++) begin : g_col
            assign st_out[NIB*j + i] = subbed[NIB*i + j];
        end
    end
endmodule

// File: rtl/pad_hash.sv
module pad_hash
    import bpc_pkg::*;
#(
    parameter int unsigned NROUNDS = 4,
    localparam int unsigned KW = DW * NROUNDS
) (
    input  word_t          addr,
    input  logic [KW-1:0]  key,
    output word_t          pad
);
    word_t chain [NROUNDS+1];

    assign chain[0] = addr;

    for (genvar r = 0; r < NROUNDS; r++) begin : g_round
        pad_round u_round (
            .st_in  (chain[r]),
            .rkey   (key[DW*r +: DW]),
            .st_out (chain[r+1])
        );
    end

    assign pad = chain[NROUNDS] ^ key[DW-1:0];
endmodule

// File: rtl/region_keys.sv
module region_keys #(
    parameter int unsigned NREG = 4,
    parameter int unsigned KW   = 64,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_clr,
    input  logic [REG_W-1:0] cfg_sel,
    input  logic [KW-1:0]    cfg_key,
    input  logic             cfg_wonce,
    input  logic [REG_W-1:0] rd_sel,
    input  logic [REG_W-1:0] wr_sel,
    output logic [KW-1:0]    rd_key,
    output logic [KW-1:0]    wr_key,
    output logic             wr_wonce
);
    logic [KW-1:0] key_q   [NREG];
    logic          wonce_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q[g]   <= '0;
                wonce_q[g] <= 1'b0;
            end else if (cfg_sel == REG_W'(g)) begin
                if (cfg_clr) begin
                    key_q[g] <= '0;
                end else if (cfg_we) begin
                    key_q[g]   <= cfg_key;
                    wonce_q[g] <= cfg_wonce;
                end
            end
        end
    end

    assign rd_key   = key_q[rd_sel];
    assign wr_key   = key_q[wr_sel];
    assign wr_wonce = wonce_q[wr_sel];
endmodule

// File: rtl/written_map.sv
module written_map #(
    parameter int unsigned IDX_W = 8,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    logic [DEPTH-1:0] mark_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
        end else if (set_en) begin
            mark_q[idx] <= 1'b1;
        end
    end

    assign hit = mark_q[idx];
endmodule

// File: rtl/bus_pad_cipher.sv
module bus_pad_cipher
    import bpc_pkg::*;
#(
    parameter int unsigned NROUNDS = 4,
    parameter int unsigned NREG    = 4,
    parameter int unsigned LOC_W   = 6,
    localparam int unsigned REG_W  = $clog2(NREG),
    localparam int unsigned KW     = DW * NROUNDS,
    localparam int unsigned IDX_W  = REG_W + LOC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_clr,
    input  logic [REG_W-1:0] cfg_sel,
    input  logic [KW-1:0]    cfg_key,
    input  logic             cfg_wonce,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [DW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_wready,
    output logic             cpu_rvalid,
    output logic [DW-1:0]    cpu_rdata,
    output logic             mem_re,
    output logic [DW-1:0]    mem_raddr,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_we,
    output logic [DW-1:0]    mem_waddr,
    output logic [DW-1:0]    mem_wdata,
    output logic             viol
);
    wstate_t state_q, state_d;

    word_t   w_addr_q, w_data_q, w_ciph_q;
    word_t   rd_pad_q;
    logic    rvalid_q, viol_q;

    logic          rd_req, wr_acc, refuse, mark_set;
    logic [KW-1:0] rd_key, wr_key;
    logic          wr_wonce, loc_hit;
    word_t         rd_pad, wr_pad;

    assign rd_req = cpu_req & ~cpu_we;
    assign wr_acc = cpu_req & cpu_we & cpu_wready;

    region_keys #(.NREG(NREG), .KW(KW)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_clr   (cfg_clr),
        .cfg_sel   (cfg_sel),
        .cfg_key   (cfg_key),
        .cfg_wonce (cfg_wonce),
        .rd_sel    (cpu_addr[DW-1 -: REG_W]),
        .wr_sel    (w_addr_q[DW-1 -: REG_W]),
        .rd_key    (rd_key),
        .wr_key    (wr_key),
        .wr_wonce  (wr_wonce)
    );

    pad_hash #(.NROUNDS(NROUNDS)) u_rd_hash (
        .addr (cpu_addr),
        .key  (rd_key),
        .pad  (rd_pad)
    );

    pad_hash #(.NROUNDS(NROUNDS)) u_wr_hash (
        .addr (w_addr_q),
        .key  (wr_key),
        .pad  (wr_pad)
    );

    written_map #(.IDX_W(IDX_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (mark_set),
        .idx    ({w_addr_q[DW-1 -: REG_W], w_addr_q[LOC_W-1:0]}),
        .hit    (loc_hit)
    );

    assign refuse   = (state_q == WS_HASH) & wr_wonce & loc_hit;
    assign mark_set = (state_q == WS_HASH) & ~refuse;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (wr_acc) state_d = WS_HASH;
            WS_HASH:  state_d = refuse ? WS_IDLE : WS_STORE;
            WS_STORE: state_d = wr_acc ? WS_HASH : WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_addr_q <= '0;
            w_data_q <= '0;
            w_ciph_q <= '0;
            rd_pad_q <= '0;
            rvalid_q <= 1'b0;
            viol_q   <= 1'b0;
        end else begin
            if (wr_acc) begin
                w_addr_q <= cpu_addr;
                w_data_q <= cpu_wdata;
            end
            if (state_q == WS_HASH) w_ciph_q <= w_data_q ^ wr_pad;
            if (rd_req) rd_pad_q <= rd_pad;
            rvalid_q <= rd_req;
            viol_q   <= refuse;
        end
    end

    // outputs
    always_comb begin
        cpu_wready = (state_q != WS_HASH);
        mem_we     = (state_q == WS_STORE);
        mem_waddr  = w_addr_q;
        mem_wdata  = w_ciph_q;
        mem_re     = rd_req;
        mem_raddr  = cpu_addr;
        cpu_rvalid = rvalid_q;
        cpu_rdata  = rvalid_q ? (mem_rdata ^ rd_pad_q) : '0;
        viol       = viol_q;
    end
endmodule

// File: rtl/bus_pad_cipher_chk.sv
module bus_pad_cipher_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_we,
    input logic cpu_wready,
    input logic cpu_rvalid,
    input logic mem_re,
    input logic mem_we,
    input logic viol
);
    logic wr_taken;
    assign wr_taken = cpu_req & cpu_we & cpu_wready;

    // R5
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_taken |=> !cpu_wready);

    // R4
    store_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8
    refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(viol && mem_we));

    // R8
    outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_taken |=> ##1 (mem_we ^ viol));

    // R3
    load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> cpu_rvalid);

    // R3
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !cpu_rvalid);
endmodule

bind bus_pad_cipher bus_pad_cipher_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_wready (cpu_wready),
    .cpu_rvalid (cpu_rvalid),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .viol       (viol)
);

// File: tb/bus_pad_cipher_bench.sv
module bus_pad_cipher_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_clr = 1'b0, cfg_wonce = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [63:0] cfg_key = '0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_wready, cpu_rvalid, mem_re, mem_we, viol;
    logic [15:0] cpu_rdata, mem_raddr, mem_waddr, mem_wdata;
    logic [15:0] mem_rdata = '0;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bus_pad_cipher u_bus_pad_cipher (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_clr(cfg_clr), .cfg_sel(cfg_sel),
        .cfg_key(cfg_key), .cfg_wonce(cfg_wonce),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wready(cpu_wready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .viol(viol)
    );

    // behavioural memory
    logic [15:0] mem_arr [logic [15:0]];
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem_arr.exists(mem_raddr) ? mem_arr[mem_raddr] : 16'h0;
        if (mem_we) mem_arr[mem_waddr] = mem_wdata;
    end

    // reference hash
    int sbox_t [16] = '{3, 8, 15, 1, 10, 6, 5, 11, 14, 13, 4, 7, 9, 0, 12, 2};

    function automatic logic [15:0] ref_pad(input logic [15:0] a, input logic [63:0] k);
        logic [15:0] s, t;
        s = a;
        for (int r = 0; r < 4; r++) begin
            s = s ^ k[16*r +: 16];
            for (int n = 0; n < 4; n++) t[4*n +: 4] = 4'(sbox_t[s[4*n +: 4]]);
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++) s[4*j + i] = t[4*i + j];
        end
        return s ^ k[15:0];
    endfunction

    // reference model state
    logic [63:0] key_m [4];
    bit          wonce_m [4];
    bit          mark_m [256];
    logic [15:0] ciph_m [logic [15:0]];
    bit          s1_v, s2_v, e_viol, e_rv;
    logic [15:0] s1_a, s1_d, s2_a, s2_d, e_rd;

    function automatic int loc(input logic [15:0] a);
        return {a[15:14], a[5:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 4; g++) begin key_m[g] = '0; wonce_m[g] = 0; end
            for (int g = 0; g < 256; g++) mark_m[g] = 0;
            ciph_m.delete();
            s1_v = 0; s2_v = 0; e_viol = 0; e_rv = 0; e_rd = '0;
        end else begin
            bit refused;
            e_rv = cpu_req && !cpu_we;
            if (e_rv)
                e_rd = (ciph_m.exists(cpu_addr) ? ciph_m[cpu_addr] : 16'h0)
                       ^ ref_pad(cpu_addr, key_m[cpu_addr[15:14]]);
            if (s2_v) ciph_m[s2_a] = s2_d;
            refused = s1_v && wonce_m[s1_a[15:14]] && mark_m[loc(s1_a)];
            e_viol  = refused;
            s2_v    = s1_v && !refused;
            if (s2_v) begin
                s2_a = s1_a;
                s2_d = s1_d ^ ref_pad(s1_a, key_m[s1_a[15:14]]);
                mark_m[loc(s1_a)] = 1;
            end
            if (cpu_req && cpu_we && !s1_v) begin
                s1_v = 1; s1_a = cpu_addr; s1_d = cpu_wdata;
            end else begin
                s1_v = 0;
            end
            if (cfg_clr) key_m[cfg_sel] = '0;
            else if (cfg_we) begin
                key_m[cfg_sel] = cfg_key; wonce_m[cfg_sel] = cfg_wonce;
            end
        end
    end

    task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison; R1 is covered by the first cycles after reset
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R5 cpu_wready", 16'(cpu_wready), 16'(!s1_v));
            cmp("R4 mem_we", 16'(mem_we), 16'(s2_v));
            if (s2_v) begin
                cmp("R4 mem_waddr", mem_waddr, s2_a);
                cmp("R4 mem_wdata", mem_wdata, s2_d);
            end
            cmp("R8 viol", 16'(viol), 16'(e_viol));
            cmp("R3 cpu_rvalid", 16'(cpu_rvalid), 16'(e_rv));
            if (e_rv) cmp("R3 cpu_rdata", cpu_rdata, e_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            cpu_req = 0; cpu_we = 0; cfg_we = 0; cfg_clr = 0;
        end
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk); #1;
        cfg_we = 0; cfg_clr = 0;
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        cfg_we = 0; cfg_clr = 0; cpu_req = 0;
        while (!cpu_wready) begin @(negedge clk); #1; end
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    endtask

    task automatic set_key(input logic [1:0] r, input logic [63:0] k, input bit wo);
        @(negedge clk); #1;
        cpu_req = 0; cfg_clr = 0;
        cfg_we = 1; cfg_sel = r; cfg_key = k; cfg_wonce = wo;
    endtask

    task automatic wipe_key(input logic [1:0] r);
        @(negedge clk); #1;
        cpu_req = 0; cfg_we = 0;
        cfg_clr = 1; cfg_sel = r;
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual running expected finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        idle(3);
        // R1 idle outputs after reset
        cmp("R1 wready", 16'(cpu_wready), 16'h1);
        cmp("R1 mem_we", 16'(mem_we), 16'h0);

        // R2 fixed vector: address 0, zero key, empty memory
        do_read(16'h0000);
        @(negedge clk);
        cmp("R2 pad vector", cpu_rdata, 16'hA244);
        idle(2);

        // R6 program keys; region 2 write-once
        set_key(2'd0, 64'h0123_4567_89AB_CDEF, 1'b0);
        set_key(2'd1, 64'hDEAD_BEEF_F00D_CAFE, 1'b0);
        set_key(2'd2, 64'h1111_2222_3333_4444, 1'b1);
        set_key(2'd3, 64'h8765_4321_0FED_CBA9, 1'b0);
        idle(1);

        // R4 / R9 stores then loads
        do_write(16'h0010, 16'h1234);
        do_write(16'h4021, 16'hABCD);
        do_write(16'hC003, 16'h5555);
        idle(4);
        do_read(16'h0010);
        do_read(16'h4021);
        do_read(16'hC003);
        idle(2);

        // R5 back-to-back stores with request held
        @(negedge clk); #1;
        cpu_req = 1; cpu_we = 1;
        for (int i = 0; i < 6; i++) begin
            cpu_addr = 16'h0100 + 16'(i); cpu_wdata = 16'h7000 + 16'(i);
            @(negedge clk); #1;
        end
        idle(4);
        for (int i = 0; i < 6; i++) do_read(16'h0100 + 16'(i));
        idle(2);

        // R8 write-once region refuses the repeat; normal region does not
        do_write(16'h8005, 16'h0AAA);
        idle(3);
        do_write(16'h8005, 16'h0BBB);
        idle(3);
        do_read(16'h8005);
        do_write(16'h0010, 16'h9999);
        idle(3);
        do_read(16'h0010);
        idle(2);

        // R7 wipe key of region 1, then load through zero key
        wipe_key(2'd1);
        idle(1);
        do_read(16'h4777);
        do_read(16'h4021);
        idle(2);

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            cfg_we = 0; cfg_clr = 0;
            cpu_req = ($urandom_range(0, 3) != 0);
            cpu_we  = $urandom_range(0, 1);
            cpu_addr  = {2'($urandom_range(0, 3)), 8'h0, 6'($urandom_range(0, 15))};
            cpu_wdata = 16'($urandom);
            if ($urandom_range(0, 40) == 0) begin
                cpu_req = 0; cfg_we = 1; cfg_sel = 2'($urandom_range(0, 3));
                cfg_key = {$urandom, $urandom}; cfg_wonce = $urandom_range(0, 1);
            end
        end
        idle(4);
        done = 1;
        summary();
        $finish;
    end
endmodule